// File: doc/BRIEF.md
# GPIO Bank Controller with Card-Bus Steering

This block controls a bank of 54 general-purpose pins through a plain 32-bit word bus. The bus has a one-cycle write strobe and read data that is registered, so it appears one cycle after the address. Each pin has a 3-bit function code and a stored level bit. The level bits are changed through separate write-one-to-set and write-one-to-clear words. A pin's output line follows its stored level only while its function code selects output, and it moves only when that level actually changes.

The block also holds four pull-configuration words, which are plain storage with fixed reset values. It drives a card-bus steering output that chooses which of two host controllers owns an external SD card bus. The steering follows the function codes of the top six pins (48 to 53). Offsets for event detection and edge/level enables read as zero and ignore writes, as do all unmapped offsets.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every function code is 0, every level bit is 0, `pin_out` is all zeros, `card_sel` is 0 (first host), and the pull words read 0xAAA95555, 0xA0AAAAAA, 0x50AAA95A and 0x00055555 at offsets 0xE4, 0xE8, 0xEC and 0xF0.
- R2: The function words sit at offsets 0x00 to 0x14. The word at offset 4*k holds pin 10*k+i in bits [3i+2:3i] for i = 0..9. Bits 31:30 read zero. Fields for pins 54 and above ignore writes and read zero.
- R3: A write to 0x1C (pins 0–31) or 0x20 (pins 32–53, data bits 21:0) sets each level bit whose data bit is 1. A write to 0x28 or 0x2C clears such bits. Data bits of 0 leave levels unchanged. Offset 0x34 reads levels 31:0, and 0x38 reads levels 53:32 in bits 21:0 with the upper bits zero.
- R4: `pin_out[p]` changes only in the cycle after a set or clear write that changes level bit p while pin p's function code is 1 (output), and it then equals the new level. A level change under any other code, or a change of function code alone, leaves `pin_out[p]` unchanged.
- R5: Writes to the level words at 0x34 and 0x38 are ignored.
- R6: The set and clear words read zero. Offsets 0x40 to 0x8C (event and enable words) and all other unmapped offsets read zero, and writes to them change no state.
- R7: The four pull words are read/write storage that return the last value written.
- R8: `card_sel` becomes 0 when a function write leaves pins 48–53 all at code 0. It becomes 1 when they are all at code 4. Otherwise it holds its value. It changes only in the cycle after a function write.
- R9: `bus_rdata` presents the register selected by the address sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte offset of a full aligned word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after address |
| pin_out | output | 54 | Per-pin output lines |
| card_sel | output | 1 | Card-bus owner: 0 first host, 1 second host |

## Verification
The bench builds the block with its default parameters: 54 pins, an 8-bit offset and the stated pull reset values. With this offset width, all 64 word offsets can be read back against a reference model after every phase. It applies every function code to every field of every function word. It walks a single set bit and a single clear bit across all 54 pins under three pin-direction patterns: all input, all output and alternating. That covers every pin's gating at both 32-bit word boundaries and at the 22-bit upper word.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int PIN_COUNT = 54,
  parameter int ADDR_W = 8,
  parameter logic [3:0][31:0] PULL_RST = {32'h00055555, 32'h50AAA95A, 32'hA0AAAAAA, 32'hAAA95555}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic                 card_sel
);
  localparam int HI_W = PIN_COUNT - 32;
  localparam int FSEL_WORDS = (PIN_COUNT + 9) / 10;
  localparam int CARD_LO = PIN_COUNT - 6;
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_LEV0 = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_LEV1 = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(8'hE4);

  logic [2:0]           fsel     [PIN_COUNT];
  logic [2:0]           fsel_nxt [PIN_COUNT];
  logic [31:0]          fsel_rd  [FSEL_WORDS];
  logic [31:0]          pull     [4];
  logic [PIN_COUNT-1:0] lev, lev_nxt, set_m, clr_m;
  logic [31:0]          rd_nxt;
  logic                 all_in, all_alt0;

  assign set_m = (bus_we && bus_addr == A_SET0) ? {{HI_W{1'b0}}, bus_wdata} :
                 (bus_we && bus_addr == A_SET1) ? {bus_wdata[HI_W-1:0], 32'b0} : '0;
  assign clr_m = (bus_we && bus_addr == A_CLR0) ? {{HI_W{1'b0}}, bus_wdata} :
                 (bus_we && bus_addr == A_CLR1) ? {bus_wdata[HI_W-1:0], 32'b0} : '0;
  assign lev_nxt = (lev | set_m) & ~clr_m;

  always_comb begin
    for (int p = 0; p < PIN_COUNT; p++) begin
      fsel_nxt[p] = fsel[p];
      if (bus_we && bus_addr == ADDR_W'(4 * (p / 10)))
        fsel_nxt[p] = bus_wdata[3*(p%10) +: 3];
    end
  end

  always_comb begin
    all_in = 1'b1;
    all_alt0 = 1'b1;
    for (int p = CARD_LO; p < PIN_COUNT; p++) begin
      if (fsel_nxt[p] != 3'd0) all_in = 1'b0;
      if (fsel_nxt[p] != 3'd4) all_alt0 = 1'b0;
    end
  end

  always_comb begin
    for (int w = 0; w < FSEL_WORDS; w++) fsel_rd[w] = '0;
    for (int p = 0; p < PIN_COUNT; p++) fsel_rd[p/10][3*(p%10) +: 3] = fsel[p];
  end

  always_comb begin
    rd_nxt = '0;
    for (int w = 0; w < FSEL_WORDS; w++)
      if (bus_addr == ADDR_W'(4 * w)) rd_nxt = fsel_rd[w];
    for (int k = 0; k < 4; k++)
      if (bus_addr == A_PULL + ADDR_W'(4 * k)) rd_nxt = pull[k];
    if (bus_addr == A_LEV0) rd_nxt = lev[31:0];
    if (bus_addr == A_LEV1) rd_nxt = {{(64-PIN_COUNT){1'b0}}, lev[PIN_COUNT-1:32]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PIN_COUNT; p++) fsel[p] <= 3'd0;
      lev       <= '0;
      pin_out   <= '0;
      card_sel  <= 1'b0;
      bus_rdata <= '0;
      for (int k = 0; k < 4; k++) pull[k] <= PULL_RST[k];
    end else begin
      bus_rdata <= rd_nxt;
      lev <= lev_nxt;
      for (int p = 0; p < PIN_COUNT; p++) begin
        fsel[p] <= fsel_nxt[p];
        if (fsel[p] == 3'd1 && lev_nxt[p] != lev[p]) pin_out[p] <= lev_nxt[p];
      end
      if (bus_we && bus_addr < ADDR_W'(4 * FSEL_WORDS)) begin
        if (all_in) card_sel <= 1'b0;
        else if (all_alt0) card_sel <= 1'b1;
      end
      for (int k = 0; k < 4; k++)
        if (bus_we && bus_addr == A_PULL + ADDR_W'(4 * k)) pull[k] <= bus_wdata;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PIN_COUNT = 54,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic                 card_sel,
  input logic [PIN_COUNT-1:0] lev
);
  logic lev_wr, wo_addr;
  assign wo_addr = bus_addr == ADDR_W'(8'h1C) || bus_addr == ADDR_W'(8'h20) ||
                   bus_addr == ADDR_W'(8'h28) || bus_addr == ADDR_W'(8'h2C);
  assign lev_wr = bus_we && wo_addr;

  // R4
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lev_wr |=> $stable(pin_out));

  // R4
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ $past(pin_out)) & (pin_out ^ lev)) == '0);

  // R5
  lev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lev_wr |=> $stable(lev));

  // R8
  card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr < ADDR_W'(8'h18)) |=> $stable(card_sel));

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wo_addr |=> bus_rdata == 32'd0);

  // R6
  evt_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(8'h40) && bus_addr <= ADDR_W'(8'h8C)) |=> bus_rdata == 32'd0);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .card_sel(card_sel), .lev(lev)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [53:0] pin_out;
  logic        card_sel;

  always #5 clk = ~clk;

  gpio_bank_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .card_sel(card_sel));

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 0;
  logic [2:0]  m_fsel [54];
  logic [53:0] m_lev = '0, m_out = '0;
  logic        m_card = 1'b0;
  logic [31:0] m_pull [4] = '{32'hAAA95555, 32'hA0AAAAAA, 32'h50AAA95A, 32'h00055555};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] v = '0;
    if (a < 8'h18 && a[1:0] == 2'b00) begin
      for (int f = 0; f < 10; f++)
        if (10 * int'(a >> 2) + f < 54) v[3*f +: 3] = m_fsel[10 * int'(a >> 2) + f];
    end else if (a == 8'h34) v = m_lev[31:0];
    else if (a == 8'h38) v = {10'b0, m_lev[53:32]};
    else if (a >= 8'hE4 && a <= 8'hF0 && a[1:0] == 2'b00) v = m_pull[(a - 8'hE4) >> 2];
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a < 8'h18) return "R2";
    if (a == 8'h34 || a == 8'h38) return "R3";
    if (a >= 8'hE4 && a <= 8'hF0) return "R7";
    return "R6";
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    logic [53:0] nl;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    nl = m_lev;
    if (a < 8'h18) begin
      for (int f = 0; f < 10; f++)
        if (10 * int'(a >> 2) + f < 54) m_fsel[10 * int'(a >> 2) + f] = d[3*f +: 3];
      if (m_fsel[48] == 0 && m_fsel[49] == 0 && m_fsel[50] == 0 && m_fsel[51] == 0 &&
          m_fsel[52] == 0 && m_fsel[53] == 0) m_card = 1'b0;
      else if (m_fsel[48] == 4 && m_fsel[49] == 4 && m_fsel[50] == 4 && m_fsel[51] == 4 &&
               m_fsel[52] == 4 && m_fsel[53] == 4) m_card = 1'b1;
    end
    if (a == 8'h1C) nl[31:0] = nl[31:0] | d;
    if (a == 8'h20) nl[53:32] = nl[53:32] | d[21:0];
    if (a == 8'h28) nl[31:0] = nl[31:0] & ~d;
    if (a == 8'h2C) nl[53:32] = nl[53:32] & ~d[21:0];
    for (int p = 0; p < 54; p++)
      if (nl[p] != m_lev[p] && m_fsel[p] == 3'd1) m_out[p] = nl[p];
    m_lev = nl;
    if (a >= 8'hE4 && a <= 8'hF0 && a[1:0] == 2'b00) m_pull[(a - 8'hE4) >> 2] = d;
    chk("R4", {10'b0, pin_out}, {10'b0, m_out}, "pin_out after write");
    chk("R8", {63'b0, card_sel}, {63'b0, m_card}, "card_sel after write");
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    chk(tag_of(a), {32'b0, bus_rdata}, {32'b0, exp_rd(a)}, $sformatf("read 0x%02h", a));
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 256; a += 4) rd(8'(a));
  endtask

  task automatic set_mode(int mode);
    for (int w = 0; w < 6; w++) begin
      logic [31:0] v = '0;
      for (int f = 0; f < 10; f++) begin
        int p = 10 * w + f;
        v[3*f +: 3] = (mode == 1 || (mode == 2 && p % 2 == 0)) ? 3'd1 : 3'd0;
      end
      wr(8'(4 * w), v);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 54; p++) m_fsel[p] = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {10'b0, pin_out}, 64'd0, "pin_out reset");
    chk("R1", {63'b0, card_sel}, 64'd0, "card_sel reset");
    rd(8'hE4); rd(8'hE8); rd(8'hEC); rd(8'hF0);
    chk("R1", {32'b0, m_pull[3]}, 64'h00055555, "model pull3 reset");
    sweep_reads();

    // R2 every code in every field
    for (int w = 0; w < 6; w++)
      for (int c = 0; c < 8; c++) begin
        logic [31:0] v = 32'hC000_0000;
        for (int f = 0; f < 10; f++) v[3*f +: 3] = 3'(c);
        wr(8'(4 * w), v);
        rd(8'(4 * w));
      end
    chk("R2", {32'b0, exp_rd(8'h14)}, 64'h0000_0FFF, "upper word fields beyond 53");

    // R3/R4 walking set/clear under three direction patterns
    for (int mode = 0; mode < 3; mode++) begin
      set_mode(mode);
      for (int b = 0; b < 54; b++) begin
        logic [7:0] sa = (b < 32) ? 8'h1C : 8'h20;
        logic [7:0] ca = (b < 32) ? 8'h28 : 8'h2C;
        logic [31:0] d = 32'd1 << (b % 32);
        wr(sa, d); rd((b < 32) ? 8'h34 : 8'h38);
        wr(sa, 32'd0); rd((b < 32) ? 8'h34 : 8'h38);
        wr(ca, d); rd((b < 32) ? 8'h34 : 8'h38);
      end
      wr(8'h1C, 32'hA5A5_5A5A); wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h34); rd(8'h38);
    end
    // R4 function change alone leaves outputs
    set_mode(0);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    set_mode(1);
    chk("R4", {10'b0, pin_out}, {10'b0, m_out}, "fsel change only");
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'h003F_FFFF);
    chk("R4", {10'b0, pin_out}, {10'b0, 54'h3F_FFFF_FFFF_FFFF}, "all outputs high");

    // R5/R6 ignored writes
    for (int a = 8'h18; a < 256; a += 4)
      if (!(a == 8'h1C || a == 8'h20 || a == 8'h28 || a == 8'h2C || (a >= 8'hE4 && a <= 8'hF0))) begin
        wr(8'(a), 32'hFFFF_FFFF);
        wr(8'(a), 32'h0);
      end
    rd(8'h34);
    chk("R5", {32'b0, exp_rd(8'h38)}, 64'h003F_FFFF, "levels kept");
    sweep_reads();

    // R7 pull storage
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'hE4 + 4 * k), 32'h1357_9BDF ^ 32'(k * 32'h1111_1111));
      rd(8'(8'hE4 + 4 * k));
    end
    sweep_reads();

    // R9 back-to-back addresses
    @(negedge clk); bus_addr = 8'h34;
    @(negedge clk); bus_addr = 8'hE4;
    chk("R9", {32'b0, bus_rdata}, {32'b0, exp_rd(8'h34)}, "latency first");
    @(negedge clk);
    chk("R9", {32'b0, bus_rdata}, {32'b0, exp_rd(8'hE4)}, "latency second");

    // R8 card steering
    set_mode(0);
    chk("R8", {63'b0, card_sel}, 64'd0, "all input");
    wr(8'h10, (32'd4 << 24) | (32'd4 << 27));
    chk("R8", {63'b0, card_sel}, 64'd0, "partial alt0 holds");
    wr(8'h14, 32'h0000_0924);
    chk("R8", {63'b0, card_sel}, 64'd1, "all alt0");
    wr(8'h14, 32'h0000_0920);
    chk("R8", {63'b0, card_sel}, 64'd1, "mixed holds");
    wr(8'h00, 32'h0);
    chk("R8", {63'b0, card_sel}, 64'd1, "unrelated word holds");
    wr(8'h10, 32'h0);
    chk("R8", {63'b0, card_sel}, 64'd1, "still mixed");
    wr(8'h14, 32'h0);
    chk("R8", {63'b0, card_sel}, 64'd0, "back to input");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule